// File: doc/BRIEF.md
# Dot-Matrix Frame Upscaler for VGA with Two-Frame Blending

This block accepts a monochrome dot-matrix picture as a stream of single-bit dots and shows it on a VGA monitor. The default picture is 128 columns by 32 rows. Source frames arrive roughly twice as fast as the monitor refresh. The block keeps two bits per dot: the dot's value in the newest frame and its value in the frame before. The shade shown for each dot is the sum of those two bits. A dot that is lit in alternate frames therefore appears at half brightness. It does not flicker or vanish when the two refresh rates beat against each other.

The VGA side generates its own sync timing. The default timing is 800 clocks per line and 525 lines per frame, with both syncs active low. Each dot is drawn as a square cell of 5x5 monitor pixels. In that cell, the last column and the last row are always black, which leaves a gap between dots. The four corners of the remaining 4x4 area are also black, so the lit area looks round. With the defaults, the picture is exactly 640 pixels wide and covers lines 80 through 239. All other visible pixels are black. The shade is driven as a 2-bit code on the red and green outputs. There is no blue output.

The dot input uses valid/ready. The block never applies back-pressure. `dot_ready` is low only during reset and from the first clock after reset it stays high, so every cycle with `dot_valid` high writes one dot.

Top module: `dmd_vga_scaler`

## Requirements
- R1: `dot_ready` is low in reset and high from the first clock after reset. A cycle with `dot_valid` low changes no stored dot, whatever `dot_sof` and `dot_bit` hold.
- R2: Accepted dots fill the picture in raster order: row 0 column 0 first, columns rising within a row, then rows rising. After the last dot the position wraps to the start. A dot accepted with `dot_sof` high is stored at row 0 column 0, and the dots after it continue from there.
- R3: The shade of a dot is the number of its two stored bits that are set (newest frame and the one before). The code is 2'd0 for off, 2'd1 for half and 2'd2 for full. The code 2'd3 never appears.
- R4: Dot (r, c) occupies pixels h = 5c..5c+4 on lines V_TOP+5r..V_TOP+5r+4, with V_TOP = 80 by default.
- R5: Within a cell, let the local coordinates be (x, y), each 0..4. The shade is shown only where x ≤ 3 and y ≤ 3 and the point is not a corner of that 4x4 area ((0,0), (0,3), (3,0), (3,3)). Every other pixel of the cell is black.
- R6: Pixels outside the picture are black. This covers lines above or below it, h ≥ 640, and all blanking.
- R7: A line lasts H_ACTIVE+16+96+48 clocks. `vga_hsync_n` is low for 96 clocks, starting 16 clocks after the end of the active pixels.
- R8: A frame lasts 480+10+2+33 lines. `vga_vsync_n` is low for 2 whole lines, starting at line 490, and it falls at a line start.
- R9: All outputs are registered with one clock of delay from the scan position. In reset both syncs are high and both colour outputs are 0. `vga_red` always equals `vga_green`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_valid | input | 1 | A dot is offered this cycle |
| dot_ready | output | 1 | Block accepts dots (always high after reset) |
| dot_sof | input | 1 | Offered dot is the first of a frame |
| dot_bit | input | 1 | Dot value, 1 = lit |
| vga_hsync_n | output | 1 | Horizontal sync, active low |
| vga_vsync_n | output | 1 | Vertical sync, active low |
| vga_red | output | 2 | Shade code on red |
| vga_green | output | 2 | Shade code on green |

## Verification
The assertions check the following on every cycle:
- the sync pulse width;
- that vsync falls only while hsync is high;
- that the colour outputs are black during horizontal sync;
- that red and green are always equal and the shade code 3 never appears;
- that ready holds high after reset.

Only the directed scenarios can show the rest: that stored dots land at the right cell positions, that the two-frame sum gives half and full shades, that the rounded cell mask is correct, that a start-of-frame marker realigns the write position, and that dots offered with valid low leave the picture unchanged.

// File: rtl/dmd_vga_pkg.sv
package dmd_vga_pkg;
  typedef enum logic [1:0] {
    SHADE_OFF  = 2'd0,
    SHADE_HALF = 2'd1,
    SHADE_FULL = 2'd2
  } shade_t;

  function automatic shade_t shade_of(input logic newest, input logic older);
    case ({newest, older})
      2'b11:          shade_of = SHADE_FULL;
      2'b10, 2'b01:   shade_of = SHADE_HALF;
      default:        shade_of = SHADE_OFF;
    endcase
  endfunction
endpackage

// File: rtl/dmd_scan_timing.sv
module dmd_scan_timing #(
  parameter int COLS     = 128,
  parameter int ROWS     = 32,
  parameter int CELL     = 5,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int V_TOP    = 80,
  localparam int CW      = $clog2(COLS),
  localparam int RW      = $clog2(ROWS),
  localparam int SW      = $clog2(CELL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          in_img,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic [SW-1:0] sx,
  output logic [SW-1:0] sy
);
  localparam int IMG_W   = COLS * CELL;
  localparam int IMG_H   = ROWS * CELL;
  localparam int H_TOTAL = IMG_W + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_IMG   = HW'(IMG_W);
  localparam logic [HW-1:0] H_IMGL  = HW'(IMG_W - 1);
  localparam logic [HW-1:0] H_SS    = HW'(IMG_W + H_FP);
  localparam logic [HW-1:0] H_SE    = HW'(IMG_W + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_T     = VW'(V_TOP);
  localparam logic [VW-1:0] V_B     = VW'(V_TOP + IMG_H);
  localparam logic [VW-1:0] V_BL    = VW'(V_TOP + IMG_H - 1);
  localparam logic [VW-1:0] V_SS    = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] V_SE    = VW'(V_ACTIVE + V_FP + V_SYNC);
  localparam logic [SW-1:0] SUB_L   = SW'(CELL - 1);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_end;

  assign line_end = (hcnt == H_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      sx   <= '0;
      col  <= '0;
      sy   <= '0;
      row  <= '0;
    end else begin
      if (line_end) begin
        hcnt <= '0;
        sx   <= '0;
        col  <= '0;
        if (vcnt == V_LAST) begin
          vcnt <= '0;
          sy   <= '0;
          row  <= '0;
        end else begin
          vcnt <= vcnt + 1'b1;
          if (vcnt >= V_T && vcnt < V_BL) begin
            if (sy == SUB_L) begin
              sy  <= '0;
              row <= row + 1'b1;
            end else begin
              sy <= sy + 1'b1;
            end
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
        if (hcnt < H_IMGL) begin
          if (sx == SUB_L) begin
            sx  <= '0;
            col <= col + 1'b1;
          end else begin
            sx <= sx + 1'b1;
          end
        end
      end
    end
  end

  assign in_img  = (hcnt < H_IMG) && (vcnt >= V_T) && (vcnt < V_B);
  assign hsync_n = !((hcnt >= H_SS) && (hcnt < H_SE));
  assign vsync_n = !((vcnt >= V_SS) && (vcnt < V_SE));
endmodule

// File: rtl/dmd_frame_store.sv
module dmd_frame_store #(
  parameter int COLS = 128,
  parameter int ROWS = 32,
  localparam int CW  = $clog2(COLS),
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sof,
  input  logic          wr_bit,
  input  logic [RW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic          rd_new,
  output logic          rd_old
);
  logic [COLS-1:0] new_q [ROWS];
  logic [COLS-1:0] old_q [ROWS];
  logic [RW-1:0]   ptr_r;
  logic [CW-1:0]   ptr_c;
  logic [RW-1:0]   pos_r;
  logic [CW-1:0]   pos_c;

  assign pos_r = wr_sof ? '0 : ptr_r;
  assign pos_c = wr_sof ? '0 : ptr_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_r <= '0;
      ptr_c <= '0;
      for (int i = 0; i < ROWS; i++) begin
        new_q[i] <= '0;
        old_q[i] <= '0;
      end
    end else if (wr_en) begin
      old_q[pos_r][pos_c] <= new_q[pos_r][pos_c];
      new_q[pos_r][pos_c] <= wr_bit;
      if (pos_c == CW'(COLS - 1)) begin
        ptr_c <= '0;
        ptr_r <= (pos_r == RW'(ROWS - 1)) ? '0 : pos_r + 1'b1;
      end else begin
        ptr_c <= pos_c + 1'b1;
        ptr_r <= pos_r;
      end
    end
  end

  assign rd_new = new_q[rd_row][rd_col];
  assign rd_old = old_q[rd_row][rd_col];
endmodule

// File: rtl/dmd_cell_shader.sv
module dmd_cell_shader
  import dmd_vga_pkg::*;
#(
  parameter int CELL = 5,
  localparam int SW  = $clog2(CELL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_img,
  input  logic [SW-1:0] sx,
  input  logic [SW-1:0] sy,
  input  logic          dot_new,
  input  logic          dot_old,
  input  logic          hsync_n_in,
  input  logic          vsync_n_in,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic [1:0]    red,
  output logic [1:0]    green
);
  localparam logic [SW-1:0] EDGE = SW'(CELL - 2);

  logic   x_rim, y_rim, in_dot;
  shade_t level;

  assign x_rim  = (sx == '0) || (sx == EDGE);
  assign y_rim  = (sy == '0) || (sy == EDGE);
  assign in_dot = (sx <= EDGE) && (sy <= EDGE) && !(x_rim && y_rim);
  assign level  = (in_img && in_dot) ? shade_of(dot_new, dot_old) : SHADE_OFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      red     <= '0;
      green   <= '0;
    end else begin
      hsync_n <= hsync_n_in;
      vsync_n <= vsync_n_in;
      red     <= level;
      green   <= level;
    end
  end
endmodule

// File: rtl/dmd_vga_scaler.sv
module dmd_vga_scaler #(
  parameter int COLS     = 128,
  parameter int ROWS     = 32,
  parameter int CELL     = 5,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int V_TOP    = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dot_valid,
  output logic       dot_ready,
  input  logic       dot_sof,
  input  logic       dot_bit,
  output logic       vga_hsync_n,
  output logic       vga_vsync_n,
  output logic [1:0] vga_red,
  output logic [1:0] vga_green
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam int SW = $clog2(CELL);

  logic          ready_q;
  logic          t_hs, t_vs, t_img;
  logic [CW-1:0] t_col;
  logic [RW-1:0] t_row;
  logic [SW-1:0] t_sx, t_sy;
  logic          d_new, d_old;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign dot_ready = ready_q;

  dmd_scan_timing #(
    .COLS(COLS), .ROWS(ROWS), .CELL(CELL),
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .V_TOP(V_TOP)
  ) u_timing (
    .clk(clk), .rst_n(rst_n),
    .hsync_n(t_hs), .vsync_n(t_vs), .in_img(t_img),
    .col(t_col), .row(t_row), .sx(t_sx), .sy(t_sy)
  );

  dmd_frame_store #(.COLS(COLS), .ROWS(ROWS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dot_valid && ready_q), .wr_sof(dot_sof), .wr_bit(dot_bit),
    .rd_row(t_row), .rd_col(t_col),
    .rd_new(d_new), .rd_old(d_old)
  );

  dmd_cell_shader #(.CELL(CELL)) u_shader (
    .clk(clk), .rst_n(rst_n),
    .in_img(t_img), .sx(t_sx), .sy(t_sy),
    .dot_new(d_new), .dot_old(d_old),
    .hsync_n_in(t_hs), .vsync_n_in(t_vs),
    .hsync_n(vga_hsync_n), .vsync_n(vga_vsync_n),
    .red(vga_red), .green(vga_green)
  );
endmodule

// File: rtl/dmd_vga_scaler_chk.sv
module dmd_vga_scaler_chk #(
  parameter int H_SYNC = 96
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dot_ready,
  input logic       vga_hsync_n,
  input logic       vga_vsync_n,
  input logic [1:0] vga_red,
  input logic [1:0] vga_green
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)            low_run <= '0;
    else if (!vga_hsync_n) low_run <= low_run + 1'b1;
    else                   low_run <= '0;
  end

  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dot_ready);

  p_no_code3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vga_red != 2'd3);

  p_black_in_hsync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vga_hsync_n |-> (vga_red == 2'd0 && vga_green == 2'd0));

  p_hsync_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vga_hsync_n) |-> (low_run == 16'(H_SYNC)));

  p_vsync_at_line_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vga_vsync_n) |-> vga_hsync_n);

  p_red_eq_green_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vga_red == vga_green);
endmodule

bind dmd_vga_scaler dmd_vga_scaler_chk #(.H_SYNC(H_SYNC)) u_chk (
  .clk(clk), .rst_n(rst_n), .dot_ready(dot_ready),
  .vga_hsync_n(vga_hsync_n), .vga_vsync_n(vga_vsync_n),
  .vga_red(vga_red), .vga_green(vga_green)
);

// File: tb/dmd_vga_scaler_bench.sv
module dmd_vga_scaler_bench;
  localparam int COLS = 16, ROWS = 4, CELL = 5;
  localparam int H_FP = 4, H_SYNC = 8, H_BP = 8;
  localparam int V_ACTIVE = 30, V_FP = 2, V_SYNC = 2, V_BP = 2, V_TOP = 5;
  localparam int IMG_W = COLS * CELL, IMG_H = ROWS * CELL;
  localparam int HT = IMG_W + H_FP + H_SYNC + H_BP;
  localparam int VT = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int FRAME = HT * VT;
  localparam int VS_START = V_ACTIVE + V_FP;

  logic clk = 0, rst_n = 0;
  logic dot_valid = 0, dot_sof = 0, dot_bit = 0;
  logic dot_ready, vga_hsync_n, vga_vsync_n;
  logic [1:0] vga_red, vga_green;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dmd_vga_scaler #(
    .COLS(COLS), .ROWS(ROWS), .CELL(CELL), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .V_TOP(V_TOP)
  ) u_dmd_vga_scaler (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit pat(input int kind, input int r, input int c);
    case (kind)
      0: pat = ((r + c) % 2) == 0;
      1: pat = (c % 3) == 0;
      default: pat = c < 8;
    endcase
  endfunction

  task automatic send_frame(input int kind);
    for (int i = 0; i < COLS * ROWS; i++) begin
      @(negedge clk);
      dot_valid = 1;
      dot_sof = (i == 0);
      dot_bit = pat(kind, i / COLS, i % COLS);
    end
    @(negedge clk);
    dot_valid = 0; dot_sof = 0; dot_bit = 0;
  endtask

  // Returns the shade shown at scan position (h, v); outputs lag one clock.
  task automatic sample_px(input int h, input int v, output int shade);
    logic pv;
    int n;
    pv = 1'b0;
    while (1) begin
      @(negedge clk);
      if (pv && !vga_vsync_n) break;
      pv = vga_vsync_n;
    end
    n = (v * HT + h) - VS_START * HT;
    if (n < 0) n += FRAME;
    repeat (n) @(negedge clk);
    if (vga_red != vga_green) check("R9", "red vs green", vga_green, vga_red);
    shade = vga_red;
  endtask

  task automatic check_dot(input string req, input int r, input int c,
                           input int x, input int y, input int exp);
    int s;
    sample_px(c * CELL + x, V_TOP + r * CELL + y, s);
    check(req, $sformatf("dot(%0d,%0d) sub(%0d,%0d)", r, c, x, y), s, exp);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R9", "hsync in reset", vga_hsync_n, 1);
    check("R9", "vsync in reset", vga_vsync_n, 1);
    check("R9", "red in reset", vga_red, 0);
    check("R1", "ready in reset", dot_ready, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "ready after reset", dot_ready, 1);
  endtask

  task automatic t_blend;
    send_frame(0);
    send_frame(1);
    for (int c = 0; c < 6; c++)
      check_dot("R3", 1, c, 1, 1, int'(pat(0, 1, c)) + int'(pat(1, 1, c)));
    check_dot("R4", 3, 15, 1, 2, int'(pat(0, 3, 15)) + int'(pat(1, 3, 15)));
    check_dot("R2", 2, 9, 2, 1, int'(pat(0, 2, 9)) + int'(pat(1, 2, 9)));
  endtask

  task automatic t_shape;
    // dot (0,0) is lit in both frames: full shade 2
    check_dot("R5", 0, 0, 1, 1, 2);
    check_dot("R5", 0, 0, 0, 0, 0);
    check_dot("R5", 0, 0, 3, 3, 0);
    check_dot("R5", 0, 0, 3, 0, 0);
    check_dot("R5", 0, 0, 4, 1, 0);
    check_dot("R5", 0, 0, 1, 4, 0);
    check_dot("R5", 0, 0, 0, 1, 2);
    check_dot("R5", 0, 0, 2, 3, 2);
  endtask

  task automatic t_outside;
    int s;
    sample_px(1, V_TOP - 1, s);            check("R6", "line above picture", s, 0);
    sample_px(1, V_TOP + IMG_H, s);        check("R6", "line below picture", s, 0);
    sample_px(IMG_W, V_TOP + 1, s);        check("R6", "right of picture", s, 0);
  endtask

  task automatic t_sync;
    int n;
    while (vga_hsync_n) @(negedge clk);
    n = 0;
    while (!vga_hsync_n) begin n++; @(negedge clk); end
    check("R7", "hsync low clocks", n, H_SYNC);
    while (vga_hsync_n) begin n++; @(negedge clk); end
    check("R7", "line period", n, HT);
    while (vga_vsync_n) @(negedge clk);
    n = 0;
    while (!vga_vsync_n) begin n++; @(negedge clk); end
    check("R8", "vsync low clocks", n, V_SYNC * HT);
    while (vga_vsync_n) begin n++; @(negedge clk); end
    check("R8", "frame period", n, FRAME);
  endtask

  task automatic t_ignore;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      dot_valid = 0; dot_sof = 1; dot_bit = 1;
    end
    @(negedge clk);
    dot_sof = 0; dot_bit = 0;
    check_dot("R1", 0, 1, 1, 1, 0);
    check_dot("R1", 0, 0, 1, 1, 2);
  endtask

  task automatic t_sof;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      dot_valid = 1; dot_sof = (i == 0); dot_bit = 1;
    end
    send_frame(2);
    // dots 0..9: older = 1, newest = pat2; later dots: older = pat1, newest = pat2
    check_dot("R2", 0, 5, 1, 1, 1 + int'(pat(2, 0, 5)));
    check_dot("R2", 2, 3, 1, 1, int'(pat(1, 2, 3)) + int'(pat(2, 2, 3)));
    check_dot("R2", 0, 12, 1, 1, int'(pat(1, 0, 12)) + int'(pat(2, 0, 12)));
  endtask

  initial begin
    t_reset;
    t_sync;
    t_blend;
    t_shape;
    t_outside;
    t_ignore;
    t_sof;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule